// File: doc/BRIEF.md
# Framebuffer Mode Geometry Checker

This block turns the raw display-mode settings of a linear framebuffer into the geometry a scan-out engine needs. From the enable setting, bits per pixel, visible resolution, virtual line width, horizontal and vertical pan values and the size of framebuffer memory, it works out five things:

- the pixel format and bytes per pixel;
- the line stride;
- the size of the visible area in bytes;
- the byte offset where scan-out starts;
- whether the mode can be shown at all.

The derived geometry is held in registers. The outputs always show the most recent mode that was accepted. A one-cycle change pulse marks every cycle in which a newly accepted mode differs from the one held before, so that downstream logic can request a full redraw.

Top module: `fbgeom_checker`

## Requirements
- R1: A mode is accepted only when bit 0 of `cfg_enable` is 1. When that bit is 0, `geo_valid` is 0 one cycle later.
- R2: A `cfg_bpp` value of 16 selects format code 1 (5-6-5 RGB) with 2 bytes per pixel.
- R3: A `cfg_bpp` value of 32 selects 4 bytes per pixel. The format code is 2 (xRGB8888, little-endian) when `cfg_big_endian` is 0, and 3 (xRGB8888, big-endian) when it is 1.
- R4: Any `cfg_bpp` value other than 16 or 32 makes the mode invalid.
- R5: When `cfg_vwidth` is smaller than `cfg_xres`, `cfg_xres` is used as the line width in pixels instead.
- R6: `geo_stride` equals the effective line width times bytes per pixel. `geo_size` equals stride times `cfg_yres`. `geo_width` and `geo_height` equal `cfg_xres` and `cfg_yres`.
- R7: `geo_offset` equals `cfg_xpan` times bytes per pixel plus `cfg_ypan` times stride, computed at 64 bits.
- R8: A mode with `cfg_xres` or `cfg_yres` below 64 is invalid. A value of exactly 64 is allowed.
- R9: A mode with offset plus size greater than `mem_bytes` is invalid. Offset plus size equal to `mem_bytes` is allowed.
- R10: All outputs are registered and reflect the inputs of the previous rising edge. During reset, `geo_valid` and `geo_change` are 0 and every geometry field is 0.
- R11: `geo_change` is 1 for exactly the cycle in which a newly accepted mode differs in any field from the geometry held before it. The first accepted mode after reset counts as a change. Re-accepting an identical mode gives no pulse.
- R12: While the mode is invalid, the geometry outputs keep the last accepted values and `geo_change` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 16 | Enable setting; bit 0 turns the display on |
| cfg_bpp | input | 16 | Bits per pixel |
| cfg_xres | input | 16 | Visible width in pixels |
| cfg_yres | input | 16 | Visible height in lines |
| cfg_vwidth | input | 16 | Virtual line width in pixels |
| cfg_xpan | input | 16 | Horizontal pan in pixels |
| cfg_ypan | input | 16 | Vertical pan in lines |
| cfg_big_endian | input | 1 | Byte order for 32-bit pixels |
| mem_bytes | input | 64 | Framebuffer memory size in bytes |
| geo_valid | output | 1 | The mode of the previous cycle is displayable |
| geo_change | output | 1 | Newly accepted geometry differs from the held geometry |
| geo_fmt | output | 2 | Format code: 1 = 5-6-5, 2 = xRGB little-endian, 3 = xRGB big-endian |
| geo_bpb | output | 3 | Bytes per pixel |
| geo_width | output | 16 | Visible width |
| geo_height | output | 16 | Visible height |
| geo_stride | output | 18 | Line stride in bytes |
| geo_size | output | 64 | Visible area in bytes |
| geo_offset | output | 64 | Scan-out start offset in bytes |

## Verification
The hardest case to reach is a mode whose end lands exactly on the memory limit. Random resolutions and pans almost never make offset plus size equal to `mem_bytes`. Directed steps therefore build a 1024 by 1024 mode at 4 bytes per pixel against a 4 MiB memory, then shift it by one pixel of pan to cross the limit. Random steps draw bits per pixel from valid and invalid values, and they re-apply the previous mode now and then. This exercises, over many cycles, both the pulse for a changed mode and its absence for an identical or invalid one.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 64;
    localparam int BPB_W    = 3;
    localparam int STRIDE_W = REG_W + 2;

    typedef enum logic [1:0] {
        FMT_NONE    = 2'd0,
        FMT_RGB565  = 2'd1,
        FMT_XRGB_LE = 2'd2,
        FMT_XRGB_BE = 2'd3
    } fb_fmt_e;

    typedef struct packed {
        fb_fmt_e               fmt;
        logic [BPB_W-1:0]      bpb;
        logic [REG_W-1:0]      width;
        logic [REG_W-1:0]      height;
        logic [STRIDE_W-1:0]   stride;
        logic [ADDR_W-1:0]     size;
        logic [ADDR_W-1:0]     offset;
    } fb_geom_t;

    // Line width actually used: never narrower than the visible width.
    function automatic logic [REG_W-1:0] eff_line_px(input logic [REG_W-1:0] vw,
                                                     input logic [REG_W-1:0] xr);
        return (vw < xr) ? xr : vw;
    endfunction
endpackage

// File: rtl/fbg_fmt_decode.sv
module fbg_fmt_decode
    import fbg_pkg::*;
(
    input  logic [REG_W-1:0] bpp,
    input  logic             big_endian,
    output fb_fmt_e          fmt,
    output logic [BPB_W-1:0] bpb,
    output logic             fmt_ok
);
    always_comb begin
        fmt    = FMT_NONE;
        bpb    = '0;
        fmt_ok = 1'b0;
        case (bpp)
            REG_W'(16): begin
                fmt    = FMT_RGB565;
                bpb    = BPB_W'(2);
                fmt_ok = 1'b1;
            end
            REG_W'(32): begin
                fmt    = big_endian ? FMT_XRGB_BE : FMT_XRGB_LE;
                bpb    = BPB_W'(4);
                fmt_ok = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fbg_geom_calc.sv
module fbg_geom_calc
    import fbg_pkg::*;
(
    input  fb_fmt_e          fmt,
    input  logic [BPB_W-1:0] bpb,
    input  logic [REG_W-1:0] xres,
    input  logic [REG_W-1:0] yres,
    input  logic [REG_W-1:0] vwidth,
    input  logic [REG_W-1:0] xpan,
    input  logic [REG_W-1:0] ypan,
    output fb_geom_t         geom
);
    logic [REG_W-1:0]    line_px;
    logic [STRIDE_W-1:0] stride;

    always_comb begin
        line_px = eff_line_px(vwidth, xres);
        stride  = STRIDE_W'(line_px) * STRIDE_W'(bpb);

        geom.fmt    = fmt;
        geom.bpb    = bpb;
        geom.width  = xres;
        geom.height = yres;
        geom.stride = stride;
        geom.size   = ADDR_W'(stride) * ADDR_W'(yres);
        geom.offset = ADDR_W'(xpan) * ADDR_W'(bpb) + ADDR_W'(ypan) * ADDR_W'(stride);
    end
endmodule

// File: rtl/fbg_mode_check.sv
module fbg_mode_check
    import fbg_pkg::*;
#(
    parameter int MIN_DIM    = 64,
    parameter int ENABLE_BIT = 0
) (
    input  logic [REG_W-1:0]  enable_reg,
    input  logic              fmt_ok,
    input  fb_geom_t          geom,
    input  logic [ADDR_W-1:0] mem_bytes,
    output logic              mode_ok
);
    logic [ADDR_W:0] end_byte;
    logic            dims_ok;
    logic            fits;

    always_comb begin
        end_byte = {1'b0, geom.offset} + {1'b0, geom.size};
        fits     = end_byte <= {1'b0, mem_bytes};
        dims_ok  = (geom.width >= REG_W'(MIN_DIM)) && (geom.height >= REG_W'(MIN_DIM));
        mode_ok  = enable_reg[ENABLE_BIT] && fmt_ok && dims_ok && fits;
    end
endmodule

// File: rtl/fbgeom_checker.sv
module fbgeom_checker
    import fbg_pkg::*;
#(
    parameter int MIN_DIM    = 64,
    parameter int ENABLE_BIT = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [REG_W-1:0]    cfg_enable,
    input  logic [REG_W-1:0]    cfg_bpp,
    input  logic [REG_W-1:0]    cfg_xres,
    input  logic [REG_W-1:0]    cfg_yres,
    input  logic [REG_W-1:0]    cfg_vwidth,
    input  logic [REG_W-1:0]    cfg_xpan,
    input  logic [REG_W-1:0]    cfg_ypan,
    input  logic                cfg_big_endian,
    input  logic [ADDR_W-1:0]   mem_bytes,
    output logic                geo_valid,
    output logic                geo_change,
    output logic [1:0]          geo_fmt,
    output logic [BPB_W-1:0]    geo_bpb,
    output logic [REG_W-1:0]    geo_width,
    output logic [REG_W-1:0]    geo_height,
    output logic [STRIDE_W-1:0] geo_stride,
    output logic [ADDR_W-1:0]   geo_size,
    output logic [ADDR_W-1:0]   geo_offset
);
    fb_fmt_e          dec_fmt;
    logic [BPB_W-1:0] dec_bpb;
    logic             dec_ok;
    fb_geom_t         cand;
    logic             cand_ok;
    fb_geom_t         held_q;
    logic             valid_q;
    logic             change_q;

    fbg_fmt_decode u_fmt (
        .bpp        (cfg_bpp),
        .big_endian (cfg_big_endian),
        .fmt        (dec_fmt),
        .bpb        (dec_bpb),
        .fmt_ok     (dec_ok)
    );

    fbg_geom_calc u_calc (
        .fmt    (dec_fmt),
        .bpb    (dec_bpb),
        .xres   (cfg_xres),
        .yres   (cfg_yres),
        .vwidth (cfg_vwidth),
        .xpan   (cfg_xpan),
        .ypan   (cfg_ypan),
        .geom   (cand)
    );

    fbg_mode_check #(
        .MIN_DIM    (MIN_DIM),
        .ENABLE_BIT (ENABLE_BIT)
    ) u_check (
        .enable_reg (cfg_enable),
        .fmt_ok     (dec_ok),
        .geom       (cand),
        .mem_bytes  (mem_bytes),
        .mode_ok    (cand_ok)
    );

    // Held geometry only moves on an accepted mode; the pulse flags a real difference.
    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            valid_q  <= 1'b0;
            change_q <= 1'b0;
        end else begin
            valid_q  <= cand_ok;
            change_q <= cand_ok && (cand != held_q);
            if (cand_ok) held_q <= cand;
        end
    end

    assign geo_valid  = valid_q;
    assign geo_change = change_q;
    assign geo_fmt    = held_q.fmt;
    assign geo_bpb    = held_q.bpb;
    assign geo_width  = held_q.width;
    assign geo_height = held_q.height;
    assign geo_stride = held_q.stride;
    assign geo_size   = held_q.size;
    assign geo_offset = held_q.offset;

    p_hold_invalid_r12: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> ($stable(held_q) && !change_q));
    p_change_needs_valid_r11: assert property (@(posedge clk) disable iff (rst)
        change_q |-> valid_q);
    p_change_differs_r11: assert property (@(posedge clk) disable iff (rst)
        change_q |-> (held_q != $past(held_q)));
    p_same_no_move_r11: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !change_q) |-> $stable(held_q));
    p_min_dims_r8: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (geo_width >= REG_W'(MIN_DIM) && geo_height >= REG_W'(MIN_DIM)));
    p_fits_mem_r9: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> ({1'b0, geo_offset} + {1'b0, geo_size} <= {1'b0, $past(mem_bytes)}));
    p_enable_seen_r1: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(cfg_enable[ENABLE_BIT]));
    p_stride_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> (ADDR_W'(geo_stride) >= ADDR_W'(geo_width) * ADDR_W'(geo_bpb)));
endmodule

// File: tb/fbgeom_checker_bench.sv
`timescale 1ns/1ps
module fbgeom_checker_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] en, bpp, xr, yr, vw, xp, yp;
    logic        be;
    logic [63:0] mem;
    logic        v, chg;
    logic [1:0]  fmt;
    logic [2:0]  bpb;
    logic [15:0] w, h;
    logic [17:0] str;
    logic [63:0] sz, off;

    int checks = 0;
    int fails  = 0;

    // Reference state: last accepted geometry
    logic [1:0]  m_fmt;
    logic [2:0]  m_bpb;
    logic [15:0] m_w, m_h;
    logic [63:0] m_str, m_sz, m_off;

    always #2 clk = ~clk;

    fbgeom_checker u_fbgeom_checker (
        .clk(clk), .rst(rst), .cfg_enable(en), .cfg_bpp(bpp), .cfg_xres(xr),
        .cfg_yres(yr), .cfg_vwidth(vw), .cfg_xpan(xp), .cfg_ypan(yp),
        .cfg_big_endian(be), .mem_bytes(mem), .geo_valid(v), .geo_change(chg),
        .geo_fmt(fmt), .geo_bpb(bpb), .geo_width(w), .geo_height(h),
        .geo_stride(str), .geo_size(sz), .geo_offset(off)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [15:0] ie, ib, ix, iy, ivw, ixp, iyp,
                        input logic ibe);
        longint unsigned bytes, lw, e_str, e_sz, e_off;
        logic [1:0] e_fmt;
        bit ok, diff;
        en = ie; bpp = ib; xr = ix; yr = iy; vw = ivw; xp = ixp; yp = iyp; be = ibe;
        ok = ie[0];                                        // R1
        if (ib == 16) begin bytes = 2; e_fmt = 2'd1; end   // R2
        else if (ib == 32) begin bytes = 4; e_fmt = ibe ? 2'd3 : 2'd2; end  // R3
        else begin bytes = 0; e_fmt = 2'd0; ok = 0; end    // R4
        lw    = (ivw < ix) ? ix : ivw;                     // R5
        e_str = lw * bytes;                                // R6
        e_sz  = e_str * iy;
        e_off = ixp * bytes + iyp * e_str;                 // R7
        if (ix < 64 || iy < 64) ok = 0;                    // R8
        if (e_off + e_sz > mem) ok = 0;                    // R9
        diff = ok && (e_fmt != m_fmt || bytes[2:0] != m_bpb || ix != m_w || iy != m_h ||
                      e_str != m_str || e_sz != m_sz || e_off != m_off);
        if (ok) begin
            m_fmt = e_fmt; m_bpb = bytes[2:0]; m_w = ix; m_h = iy;
            m_str = e_str; m_sz = e_sz; m_off = e_off;
        end
        @(negedge clk);
        check(v == ok, tag, "valid", v, ok);
        check(chg == diff, tag, "change", chg, diff);                // R11/R12
        check(fmt == m_fmt && bpb == m_bpb, tag, "fmt/bpb", {fmt, bpb}, {m_fmt, m_bpb});
        check(w == m_w && h == m_h, tag, "width/height", {w, h}, {m_w, m_h});
        check(str == m_str, tag, "stride", str, m_str);
        check(sz == m_sz, tag, "size", sz, m_sz);
        check(off == m_off, tag, "offset", off, m_off);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] bl [4];
        void'($urandom(32'd20240611));
        bl[0] = 16; bl[1] = 32; bl[2] = 8; bl[3] = 24;
        m_fmt = 0; m_bpb = 0; m_w = 0; m_h = 0; m_str = 0; m_sz = 0; m_off = 0;
        en = 0; bpp = 0; xr = 0; yr = 0; vw = 0; xp = 0; yp = 0; be = 0;
        mem = 64'd4194304;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(v == 0 && chg == 0, "R10", "reset valid/change", {v, chg}, 0);
        check(sz == 0 && off == 0 && str == 0 && w == 0, "R10", "reset geometry", sz | off, 0);
        rst = 1'b0;

        step("R10_first_R11", 1, 32, 640, 480, 0, 0, 0, 0);
        step("R11_same", 1, 32, 640, 480, 0, 0, 0, 0);
        step("R3_be", 1, 32, 640, 480, 0, 0, 0, 1);
        step("R2_rgb565", 1, 16, 800, 600, 0, 0, 0, 0);
        step("R1_disabled", 0, 16, 1024, 768, 0, 0, 0, 0);
        step("R12_hold", 1, 8, 1024, 768, 0, 0, 0, 0);
        step("R4_bpp24", 1, 24, 640, 480, 0, 0, 0, 0);
        step("R8_w63", 1, 32, 63, 480, 0, 0, 0, 0);
        step("R8_h63", 1, 32, 640, 63, 0, 0, 0, 0);
        step("R8_64x64", 1, 32, 64, 64, 0, 0, 0, 0);
        step("R5_clamp", 1, 16, 320, 200, 100, 0, 0, 0);
        step("R5_wider", 1, 16, 320, 200, 400, 0, 0, 0);
        step("R7_pan", 1, 32, 320, 200, 400, 17, 9, 0);
        step("R9_exact", 1, 32, 1024, 1024, 0, 0, 0, 0);
        step("R9_over", 1, 32, 1024, 1024, 0, 1, 0, 0);
        step("R9_exact_again", 1, 32, 1024, 1024, 0, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 8) == 0) begin
                step("R11_repeat", en, bpp, xr, yr, vw, xp, yp, be);
            end else begin
                step("R6_random",
                     16'(($urandom % 16) != 0),
                     bl[$urandom % 4],
                     16'($urandom % 1200),
                     16'($urandom % 1000),
                     16'($urandom % 1400),
                     16'($urandom % 300),
                     16'($urandom % 300),
                     1'($urandom % 2));
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule